// File: doc/BRIEF.md
# Row Lane Aligner

This block sits between a load/store unit and a small data memory that is organised as 64-bit rows of eight bytes. Each request carries a byte address, an access size of one, two, four or eight bytes, a direction, a byte-reversal flag and, for stores, the data to be written. The address selects a row and a byte offset within that row. Loads return the addressed bytes right-justified. Stores merge the new bytes into the addressed row and leave the other bytes of that row unchanged.

An access whose offset is not a multiple of its size is rejected. It returns an error response and does not touch the memory. When the reversal flag is set, the bytes inside the access size are put in reverse order. For loads this is applied to the returned value, and for stores to the data before it is written. The storage is a parameterised array of rows inside the block. Reset clears every row, so a row that has never been written reads as zero.

Top module: `row_lane_aligner`

## Requirements
- R1: The row index is the address shifted right by three, taken modulo DEPTH (for example, 0x0208 selects row 1). The byte offset is address bits [2:0]. Byte k of a row occupies row bits [8k+7:8k].
- R2: `req_size` gives the access size: code 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes.
- R3: A request is misaligned when the offset ANDed with (size in bytes − 1) is nonzero. Such a request gets a response with `rsp_err`=1 and `rsp_rdata`=0, and the row is not modified.
- R4: A load narrower than 8 bytes returns row bytes offset to offset+size−1 in result bytes 0 upward, and all higher result bits are 0.
- R5: A store narrower than 8 bytes replaces only row bytes offset to offset+size−1, taking them from the low bytes of `req_wdata`. Higher bits of `req_wdata` are ignored.
- R6: An 8-byte store overwrites the whole row, and an 8-byte load returns the whole row.
- R7: With `req_swap`=1, byte i of the access becomes byte size−1−i. This applies to load results and to store data.
- R8: Every accepted request gives exactly one `rsp_valid` pulse, in the cycle after acceptance. Store responses carry `rsp_rdata`=0. No pulse appears without a request.
- R9: After reset all rows read as zero and `rsp_valid` is low.
- R10: `req_ready` is high whenever reset is released, so a request can be accepted every cycle. A load in the cycle right after a store sees the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 for store, 0 for load |
| req_swap | input | 1 | Reverse bytes within the access size |
| req_size | input | 2 | Access size code (R2) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store data, right-justified |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is a misalignment error |
| rsp_rdata | output | 64 | Load result, right-justified |

## Verification
Each result is due one cycle after acceptance. A request is accepted on a rising edge, and the response registers capture the result on that same edge. The memory update from a store is visible to the next request. The bench drives each request on a falling edge. It reads `rsp_valid`, `rsp_err` and `rsp_rdata` on the next falling edge, which is half a period after the accepting edge. It uses full-row loads to bring out row contents after every store or rejected request.

// File: rtl/row_lane_pkg.sv
package row_lane_pkg;

  localparam int ROW_BYTES = 8;
  localparam int ROW_BITS  = ROW_BYTES * 8;
  localparam int OFF_W     = $clog2(ROW_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_ROW  = 2'd3
  } acc_size_e;

  // number of bytes for a size code
  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction

  // byte-lane pattern of an access starting at offset 0
  function automatic logic [7:0] lane_pattern(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 8'h01;
      SZ_HALF: return 8'h03;
      SZ_WORD: return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  // value mask of width size*8, right-justified
  function automatic logic [ROW_BITS-1:0] width_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 64'h0000_0000_0000_00FF;
      SZ_HALF: return 64'h0000_0000_0000_FFFF;
      SZ_WORD: return 64'h0000_0000_FFFF_FFFF;
      default: return {ROW_BITS{1'b1}};
    endcase
  endfunction

  // offset not a multiple of the access size
  function automatic logic off_misaligned(input logic [OFF_W-1:0] off,
                                          input logic [1:0] sz);
    logic [3:0] low;
    low = size_bytes(sz) - 4'd1;
    return ({1'b0, off} & low) != 4'd0;
  endfunction

  // reverse the byte order inside the access size, zero above it
  function automatic logic [ROW_BITS-1:0] swap_bytes(input logic [ROW_BITS-1:0] d,
                                                     input logic [1:0] sz);
    logic [ROW_BITS-1:0] r;
    int n;
    n = int'(size_bytes(sz));
    r = '0;
    for (int i = 0; i < ROW_BYTES; i++) begin
      if (i < n) r[8*i +: 8] = d[8*(n-1-i) +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/row_addr_split.sv
module row_addr_split
  import row_lane_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ROW_AW = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [ROW_AW-1:0] row_idx,
  output logic [5:0]        lane_shift,
  output logic [7:0]        byte_en,
  output logic              bad_align
);

  logic [OFF_W-1:0] byte_off;

  assign row_idx    = ROW_AW'(addr >> OFF_W);
  assign byte_off   = addr[OFF_W-1:0];
  assign lane_shift = {byte_off, 3'b000};
  assign byte_en    = 8'(lane_pattern(size) << byte_off);
  assign bad_align  = off_misaligned(byte_off, size);

endmodule

// File: rtl/row_store.sv
module row_store
  import row_lane_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ROW_AW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ROW_AW-1:0]   idx,
  input  logic [ROW_BITS-1:0] wdata,
  output logic [ROW_BITS-1:0] rdata
);

  logic [ROW_BITS-1:0] rows [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < DEPTH; r++) rows[r] <= '0;
    end else if (we) begin
      rows[idx] <= wdata;
    end
  end

  assign rdata = rows[idx];

endmodule

// File: rtl/lane_merge.sv
module lane_merge
  import row_lane_pkg::*;
(
  input  logic [ROW_BITS-1:0] row_q,
  input  logic [ROW_BITS-1:0] st_data,
  input  logic [1:0]          size,
  input  logic                swap,
  input  logic [5:0]          lane_shift,
  input  logic [7:0]          byte_en,
  output logic [ROW_BITS-1:0] ld_value,
  output logic [ROW_BITS-1:0] merged_row
);

  logic [ROW_BITS-1:0] field_mask;
  logic [ROW_BITS-1:0] extracted;
  logic [ROW_BITS-1:0] st_trim;
  logic [ROW_BITS-1:0] st_ordered;
  logic [ROW_BITS-1:0] st_placed;

  for (genvar i = 0; i < ROW_BYTES; i++) begin : g_lane
    assign field_mask[8*i +: 8] = {8{byte_en[i]}};
    assign merged_row[8*i +: 8] = byte_en[i] ? st_placed[8*i +: 8] : row_q[8*i +: 8];
  end

  assign extracted  = (row_q & field_mask) >> lane_shift;
  assign ld_value   = swap ? swap_bytes(extracted, size) : extracted;

  assign st_trim    = st_data & width_mask(size);
  assign st_ordered = swap ? swap_bytes(st_trim, size) : st_trim;
  assign st_placed  = st_ordered << lane_shift;

endmodule

// File: rtl/row_lane_aligner.sv
module row_lane_aligner
  import row_lane_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_swap,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_rdata
);

  localparam int ROW_AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              ready_q;
  logic              fire;
  logic              wr_fire;
  logic              ld_ok;
  logic [ROW_AW-1:0] row_idx;
  logic [5:0]        lane_shift;
  logic [7:0]        byte_en;
  logic              bad_align;
  logic [63:0]       row_q;
  logic [63:0]       ld_value;
  logic [63:0]       merged_row;
  logic              rsp_valid_q;
  logic              rsp_err_q;
  logic [63:0]       rsp_data_q;

  row_addr_split #(.ADDR_W(ADDR_W), .ROW_AW(ROW_AW)) u_split (
    .addr       (req_addr),
    .size       (req_size),
    .row_idx    (row_idx),
    .lane_shift (lane_shift),
    .byte_en    (byte_en),
    .bad_align  (bad_align)
  );

  row_store #(.DEPTH(DEPTH), .ROW_AW(ROW_AW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_fire),
    .idx   (row_idx),
    .wdata (merged_row),
    .rdata (row_q)
  );

  lane_merge u_merge (
    .row_q      (row_q),
    .st_data    (req_wdata),
    .size       (req_size),
    .swap       (req_swap),
    .lane_shift (lane_shift),
    .byte_en    (byte_en),
    .ld_value   (ld_value),
    .merged_row (merged_row)
  );

  assign fire    = req_valid & ready_q;
  assign wr_fire = fire & req_write & ~bad_align;
  assign ld_ok   = fire & ~req_write & ~bad_align;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      ready_q     <= 1'b1;
      rsp_valid_q <= fire;
      rsp_err_q   <= fire & bad_align;
      rsp_data_q  <= ld_ok ? ld_value : '0;
    end
  end

  assign req_ready = ready_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_data_q;

endmodule

// File: rtl/row_lane_aligner_chk.sv
module row_lane_aligner_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [1:0]  req_size,
  input logic [2:0]  addr_lo,
  input logic        wr_fire,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [63:0] rsp_rdata
);

  logic       acc;
  logic [3:0] nbytes;
  logic       port_mis;

  assign acc      = req_valid & req_ready;
  assign nbytes   = 4'd1 << req_size;
  assign port_mis = ({1'b0, addr_lo} & (nbytes - 4'd1)) != 4'd0;

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid); // R8
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid); // R8
  AST_STORE_RSP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write) |=> (rsp_rdata == 64'd0)); // R8
  AST_MISALIGN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && port_mis) |=> (rsp_err && rsp_rdata == 64'd0)); // R3
  AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && port_mis) |-> !wr_fire); // R3
  AST_ERR_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid); // R3
  AST_BYTE_LOAD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_size == 2'd0) |=> (rsp_rdata[63:8] == 56'd0)); // R4
  AST_HALF_LOAD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_size == 2'd1) |=> (rsp_rdata[63:16] == 48'd0)); // R4
  AST_WORD_LOAD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_size == 2'd2) |=> (rsp_rdata[63:32] == 32'd0)); // R4

endmodule

bind row_lane_aligner row_lane_aligner_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_size  (req_size),
  .addr_lo   (req_addr[2:0]),
  .wr_fire   (wr_fire),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata)
);

// File: tb/row_lane_aligner_test.sv
module row_lane_aligner_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_swap;
  logic [1:0]  req_size;
  logic [15:0] req_addr;
  logic [63:0] req_wdata;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;

  int checks = 0;
  int bad    = 0;

  always #10 clk = ~clk;

  row_lane_aligner uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_swap(req_swap), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  typedef struct packed {
    logic        wr;
    logic        sw;
    logic [1:0]  sz;
    logic [15:0] addr;
    logic [63:0] wd;
    logic [63:0] exp;
    logic        err;
    logic [7:0]  rq;
  } vec_t;

  // memory starts cleared; vectors run in order
  localparam vec_t VT [21] = '{
    '{1'b1, 1'b0, 2'd3, 16'h0010, 64'h8877665544332211, 64'h0, 1'b0, 8'd6},                // R6 full store
    '{1'b0, 1'b0, 2'd3, 16'h0010, 64'h0, 64'h8877665544332211, 1'b0, 8'd6},                // R6 full load
    '{1'b0, 1'b0, 2'd0, 16'h0013, 64'h0, 64'h44, 1'b0, 8'd4},                              // R4 byte 3
    '{1'b0, 1'b0, 2'd1, 16'h0016, 64'h0, 64'h8877, 1'b0, 8'd4},                            // R4 half at 6
    '{1'b0, 1'b1, 2'd2, 16'h0014, 64'h0, 64'h55667788, 1'b0, 8'd7},                        // R7 swapped load
    '{1'b1, 1'b0, 2'd1, 16'h0012, 64'hBEEF, 64'h0, 1'b0, 8'd5},                            // R5 half store
    '{1'b0, 1'b0, 2'd3, 16'h0010, 64'h0, 64'h88776655BEEF2211, 1'b0, 8'd5},                // R5 merge seen
    '{1'b1, 1'b1, 2'd2, 16'h0014, 64'hA1B2C3D4, 64'h0, 1'b0, 8'd7},                        // R7 swapped store
    '{1'b0, 1'b0, 2'd3, 16'h0010, 64'h0, 64'hD4C3B2A1BEEF2211, 1'b0, 8'd7},                // R7 result
    '{1'b1, 1'b0, 2'd1, 16'h0013, 64'hFFFF, 64'h0, 1'b1, 8'd3},                            // R3 misaligned store
    '{1'b0, 1'b0, 2'd3, 16'h0010, 64'h0, 64'hD4C3B2A1BEEF2211, 1'b0, 8'd3},                // R3 row untouched
    '{1'b0, 1'b0, 2'd2, 16'h0012, 64'h0, 64'h0, 1'b1, 8'd3},                               // R3 misaligned load
    '{1'b0, 1'b0, 2'd3, 16'h0020, 64'h0, 64'h0, 1'b0, 8'd9},                               // R9 unwritten row
    '{1'b0, 1'b1, 2'd3, 16'h0010, 64'h0, 64'h1122EFBEA1B2C3D4, 1'b0, 8'd7},                // R7 full swap
    '{1'b1, 1'b0, 2'd0, 16'h0017, 64'hFFFF_FFFF_FFFF_F1FF, 64'h0, 1'b0, 8'd5},             // R5 upper ignored
    '{1'b0, 1'b0, 2'd3, 16'h0010, 64'h0, 64'hFFC3B2A1BEEF2211, 1'b0, 8'd5},                // R5 one byte changed
    '{1'b1, 1'b1, 2'd3, 16'h0018, 64'h0102030405060708, 64'h0, 1'b0, 8'd7},                // R7 full swapped store
    '{1'b0, 1'b0, 2'd0, 16'h0018, 64'h0, 64'h01, 1'b0, 8'd2},                              // R2 size code 0
    '{1'b0, 1'b0, 2'd3, 16'h0018, 64'h0, 64'h0807060504030201, 1'b0, 8'd2},                // R2 size code 3
    '{1'b1, 1'b0, 2'd3, 16'h0208, 64'hCAFE, 64'h0, 1'b0, 8'd1},                            // R1 wraps to row 1
    '{1'b0, 1'b0, 2'd3, 16'h0008, 64'h0, 64'hCAFE, 1'b0, 8'd1}                             // R1 alias read
  };

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive on a falling edge, sample on the next falling edge
  task automatic issue(input logic wr, input logic sw, input logic [1:0] sz,
                       input logic [15:0] a, input logic [63:0] wd,
                       output logic v, output logic e, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_swap = sw;
    req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    v = rsp_valid; e = rsp_err; d = rsp_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic v, e;
    logic [63:0] d;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_swap = 1'b0;
    req_size = 2'd0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 64'd1);

    for (int k = 0; k < 21; k++) begin
      issue(VT[k].wr, VT[k].sw, VT[k].sz, VT[k].addr, VT[k].wd, v, e, d);
      chk(v == 1'b1, $sformatf("R8 vector %0d rsp_valid", k), 64'(v), 64'd1);
      chk(e == VT[k].err, $sformatf("R%0d vector %0d rsp_err", VT[k].rq, k),
          64'(e), 64'(VT[k].err));
      chk(d == VT[k].exp, $sformatf("R%0d vector %0d rsp_rdata", VT[k].rq, k),
          d, VT[k].exp);
    end

    // R8: idle cycles give no response
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 idle no response", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 idle no response 2", 64'(rsp_valid), 64'd0);

    // R10: store then load in consecutive cycles
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_swap = 1'b0; req_size = 2'd3;
    req_addr = 16'h0028; req_wdata = 64'h123456789ABCDEF0;
    @(negedge clk);
    chk(rsp_valid == 1'b1 && rsp_rdata == 64'd0, "R10 store response",
        rsp_rdata, 64'd0);
    req_write = 1'b0; req_size = 2'd1; req_addr = 16'h002A; req_wdata = '0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R10 back-to-back valid", 64'(rsp_valid), 64'd1);
    chk(rsp_rdata == 64'h9ABC, "R10 back-to-back load", rsp_rdata, 64'h9ABC);

    // R9: reset clears rows again
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    issue(1'b0, 1'b0, 2'd3, 16'h0010, 64'd0, v, e, d);
    chk(d == 64'd0, "R9 row cleared by reset", d, 64'd0);
    issue(1'b0, 1'b0, 2'd3, 16'h0028, 64'd0, v, e, d);
    chk(d == 64'd0, "R9 second row cleared", d, 64'd0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule